// File: doc/BRIEF.md
# Processor Power-State Controller

This block follows a processor core through its low-power states and requests the special bus cycles that announce each change. The five states are run, halted (automatic power-down after a halt instruction), stop-grant, clock-stopped, and a one-clock snoop state. Inputs are a halt-executed strobe, an active-low stop-clock request and an indicator that the input clock is running. The block also takes the wake-up lines (maskable interrupt, non-maskable interrupt, active-low management interrupt, soft reset), a synchronous core reset, and the bus-arbitration and snoop inputs (bus hold, address hold, active-low back-off, active-low external snoop strobe).

The block drives a single-cycle bus-cycle request with a one-bit cycle type (0 = halt cycle, 1 = stop-grant cycle), a bus-float enable, a one-cycle core-clock enable for snoops, and a 3-bit state code (0 run, 1 halted, 2 stop-grant, 3 clock stopped, 4 snoop). A frozen core is woken for one clock to serve a snoop and then put back silently. After the clock restarts, leaving the clock-stopped state waits for a parameterised lock time, counted in reference-clock ticks.

Top module: `pwr_state_ctrl`

## Requirements
- R1: An asserted `rst_n` (low) or a sampled `core_reset` forces state code 0 with no bus request, core clock enable low and bus float low on the next cycle, whatever the state and other inputs.
- R2: `halt_exec` sampled in state 0 with the stop request inactive gives, on the next cycle, a one-cycle bus request of type 0 while the state code is still 0. The state code becomes 1 on the cycle after that.
- R3: In state 1, any of `irq_maskable` high, `irq_nonmask` high, `irq_mgmt_n` low or `soft_reset` high returns the state code to 0 on the next cycle, with no bus request.
- R4: `stop_req_n` low in state 0, or in state 1 with no wake event, moves to state 2 on the next cycle with a bus request of type 1 on that same cycle.
- R5: `stop_req_n` high in state 2 with the clock running returns to state 1 with a bus request of type 0 if stop-grant was entered from state 1. It returns to state 0 with no bus request if stop-grant was entered from state 0.
- R6: `clk_running` low moves state 2 to state 3 on the next cycle. This has priority over a stop-request release and a snoop, and a stopped clock has no effect on state in any other state.
- R7: In state 3 the block returns to state 2, with no bus request, only after `LOCK_TICKS` consecutive sampled cycles of `clk_running` high. A low sample restarts the count, and interrupts and snoops are ignored while the clock is stopped.
- R8: `bus_float` is high exactly when the state code is 1, 2 or 4 and at least one of `bus_hold_req` high, `addr_hold_req` high or `backoff_req_n` low is present. It follows those inputs combinationally.
- R9: `snoop_req_n` low in state 1 or 2, with no higher-priority event, gives state code 4 with `core_clk_en` high for exactly one cycle. The block then returns to the earlier state with no bus request. `core_clk_en` is never high outside state 4.
- R10: A maskable interrupt raised while the clock is stopped and held steady causes a return to state 0 once the clock has relocked and the stop request is released (via state 2 then state 1).
- R11: Every bus request is a single-cycle pulse per transition; requests only appear on entering state 2, on the halt announcement, or on a return from state 2 to state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| core_reset | input | 1 | Synchronous core reset, highest priority |
| soft_reset | input | 1 | Soft reset, wake event from halted state |
| halt_exec | input | 1 | Strobe: halt instruction executed |
| stop_req_n | input | 1 | Active-low stop-clock request |
| clk_running | input | 1 | High while the input clock toggles |
| irq_maskable | input | 1 | Maskable interrupt request |
| irq_nonmask | input | 1 | Non-maskable interrupt request |
| irq_mgmt_n | input | 1 | Active-low management interrupt |
| bus_hold_req | input | 1 | Bus hold request |
| addr_hold_req | input | 1 | Address hold request |
| backoff_req_n | input | 1 | Active-low bus back-off |
| snoop_req_n | input | 1 | Active-low external snoop address strobe |
| bus_cyc_req | output | 1 | One-cycle special bus cycle request |
| bus_cyc_type | output | 1 | 0 halt cycle, 1 stop-grant cycle |
| bus_float | output | 1 | Float the bus |
| core_clk_en | output | 1 | One-cycle core clock enable for a snoop |
| state_code | output | 3 | Current power state code |

## Verification
On every cycle the assertions check the following properties. A core reset always lands in state 0 silently. A halt-type request in state 0 is always followed by state 1. A stop-grant request only coincides with state 2, and state 3 is only reached from state 2 and stays silent. Bus float is never high in states 0 and 3, and a snoop lasts one cycle and returns to its origin state. Other behaviour can only be shown by the bench's scenarios against its reference model. This covers the exact length of the relock wait and its restart on a gap, and the choice between halted and run when stop-grant ends. It also covers each of the four wake sources and an interrupt held across a stopped clock being serviced.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  localparam int unsigned CODE_W = 3;

  typedef enum logic [2:0] {
    PS_RUN           = 3'd0,
    PS_HALTED        = 3'd1,
    PS_GRANT         = 3'd2,
    PS_CLKOFF        = 3'd3,
    PS_SNOOP         = 3'd4,
    PS_HALT_ANNOUNCE = 3'd5
  } pstate_e;

  typedef enum logic {
    CYC_HALT  = 1'b0,
    CYC_GRANT = 1'b1
  } cyc_e;

endpackage

// File: rtl/pwr_event_decode.sv
module pwr_event_decode #(
  parameter int unsigned      N_WAKE        = 4,
  parameter logic [N_WAKE-1:0] WAKE_LOW_MASK = '0,
  parameter int unsigned      N_HOLD        = 3,
  parameter logic [N_HOLD-1:0] HOLD_LOW_MASK = '0
) (
  input  logic [N_WAKE-1:0] wake_raw,
  input  logic [N_HOLD-1:0] hold_raw,
  input  logic              stop_req_n,
  input  logic              snoop_req_n,
  output logic              wake_evt,
  output logic              hold_any,
  output logic              stop_act,
  output logic              snoop_act
);

  logic [N_WAKE-1:0] wake_hi;
  logic [N_HOLD-1:0] hold_hi;

  // Normalise every source to active-high according to its polarity bit.
  genvar gi;
  generate
    for (gi = 0; gi < N_WAKE; gi++) begin : g_wake
      if (WAKE_LOW_MASK[gi]) begin : g_low
        assign wake_hi[gi] = ~wake_raw[gi];
      end else begin : g_high
        assign wake_hi[gi] = wake_raw[gi];
      end
    end
    for (gi = 0; gi < N_HOLD; gi++) begin : g_hold
      if (HOLD_LOW_MASK[gi]) begin : g_low
        assign hold_hi[gi] = ~hold_raw[gi];
      end else begin : g_high
        assign hold_hi[gi] = hold_raw[gi];
      end
    end
  endgenerate

  assign wake_evt  = |wake_hi;
  assign hold_any  = |hold_hi;
  assign stop_act  = ~stop_req_n;
  assign snoop_act = ~snoop_req_n;

endmodule

// File: rtl/pwr_lock_timer.sv
module pwr_lock_timer #(
  parameter int unsigned LOCK_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic clk_running,
  output logic lock_done
);

  localparam int unsigned        CNT_W = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS) : 1;
  localparam logic [CNT_W-1:0]   LAST  = CNT_W'(LOCK_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_we;

  assign lock_done = count_en & clk_running & (cnt_q == LAST);

  always_comb begin
    cnt_we = count_en | (cnt_q != '0);
    if (!count_en || !clk_running || lock_done) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pwr_cycle_gen.sv
module pwr_cycle_gen
  import pwr_state_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  cyc_e fire_type,
  output logic req,
  output cyc_e req_type
);

  logic req_q;
  cyc_e type_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= CYC_HALT;
    end else if (fire) begin
      type_q <= fire_type;
    end
  end

  assign req      = req_q;
  assign req_type = type_q;

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int unsigned LOCK_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_reset,
  input  logic              soft_reset,
  input  logic              halt_exec,
  input  logic              stop_req_n,
  input  logic              clk_running,
  input  logic              irq_maskable,
  input  logic              irq_nonmask,
  input  logic              irq_mgmt_n,
  input  logic              bus_hold_req,
  input  logic              addr_hold_req,
  input  logic              backoff_req_n,
  input  logic              snoop_req_n,
  output logic              bus_cyc_req,
  output logic              bus_cyc_type,
  output logic              bus_float,
  output logic              core_clk_en,
  output logic [CODE_W-1:0] state_code
);

  pstate_e st_q, st_d;
  pstate_e ret_q, ret_d;
  logic    from_halt_q, from_halt_d;
  logic    ret_we, from_halt_we;
  logic    fire;
  cyc_e    fire_type;
  cyc_e    req_type;

  logic wake_evt, hold_any, stop_act, snoop_act, lock_done;
  logic frozen;

  pwr_event_decode #(
    .N_WAKE        (4),
    .WAKE_LOW_MASK (4'b0100),
    .N_HOLD        (3),
    .HOLD_LOW_MASK (3'b100)
  ) u_decode (
    .wake_raw    ({soft_reset, irq_mgmt_n, irq_nonmask, irq_maskable}),
    .hold_raw    ({backoff_req_n, addr_hold_req, bus_hold_req}),
    .stop_req_n  (stop_req_n),
    .snoop_req_n (snoop_req_n),
    .wake_evt    (wake_evt),
    .hold_any    (hold_any),
    .stop_act    (stop_act),
    .snoop_act   (snoop_act)
  );

  pwr_lock_timer #(
    .LOCK_TICKS (LOCK_TICKS)
  ) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_en    (st_q == PS_CLKOFF),
    .clk_running (clk_running),
    .lock_done   (lock_done)
  );

  pwr_cycle_gen u_cyc (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .fire_type (fire_type),
    .req       (bus_cyc_req),
    .req_type  (req_type)
  );

  // Next-state process
  always_comb begin
    st_d         = st_q;
    ret_d        = ret_q;
    from_halt_d  = from_halt_q;
    ret_we       = 1'b0;
    from_halt_we = 1'b0;
    fire         = 1'b0;
    fire_type    = CYC_HALT;
    if (core_reset) begin
      st_d         = PS_RUN;
      from_halt_d  = 1'b0;
      from_halt_we = 1'b1;
    end else begin
      unique case (st_q)
        PS_RUN: begin
          if (stop_act) begin
            st_d         = PS_GRANT;
            fire         = 1'b1;
            fire_type    = CYC_GRANT;
            from_halt_d  = 1'b0;
            from_halt_we = 1'b1;
          end else if (halt_exec) begin
            st_d      = PS_HALT_ANNOUNCE;
            fire      = 1'b1;
            fire_type = CYC_HALT;
          end
        end
        PS_HALT_ANNOUNCE: begin
          st_d = PS_HALTED;
        end
        PS_HALTED: begin
          if (wake_evt) begin
            st_d = PS_RUN;
          end else if (stop_act) begin
            st_d         = PS_GRANT;
            fire         = 1'b1;
            fire_type    = CYC_GRANT;
            from_halt_d  = 1'b1;
            from_halt_we = 1'b1;
          end else if (snoop_act) begin
            st_d   = PS_SNOOP;
            ret_d  = PS_HALTED;
            ret_we = 1'b1;
          end
        end
        PS_GRANT: begin
          if (!clk_running) begin
            st_d = PS_CLKOFF;
          end else if (!stop_act) begin
            if (from_halt_q) begin
              st_d      = PS_HALTED;
              fire      = 1'b1;
              fire_type = CYC_HALT;
            end else begin
              st_d = PS_RUN;
            end
          end else if (snoop_act) begin
            st_d   = PS_SNOOP;
            ret_d  = PS_GRANT;
            ret_we = 1'b1;
          end
        end
        PS_CLKOFF: begin
          if (lock_done) begin
            st_d = PS_GRANT;
          end
        end
        PS_SNOOP: begin
          st_d = ret_q;
        end
        default: begin
          st_d = PS_RUN;
        end
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_RUN;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q <= PS_HALTED;
    end else if (ret_we) begin
      ret_q <= ret_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      from_halt_q <= 1'b0;
    end else if (from_halt_we) begin
      from_halt_q <= from_halt_d;
    end
  end

  assign frozen       = (st_q == PS_HALTED) | (st_q == PS_GRANT) | (st_q == PS_SNOOP);
  assign bus_float    = frozen & hold_any;
  assign core_clk_en  = (st_q == PS_SNOOP);
  assign bus_cyc_type = (req_type == CYC_GRANT);
  assign state_code   = (st_q == PS_HALT_ANNOUNCE) ? CODE_W'(PS_RUN) : CODE_W'(st_q);

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       core_reset,
  input logic       bus_cyc_req,
  input logic       bus_cyc_type,
  input logic       bus_float,
  input logic       core_clk_en,
  input logic [2:0] state_code
);

  AST_CORE_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> (state_code == 3'd0 && !bus_cyc_req)); // R1

  AST_HALT_CYCLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc_req && !bus_cyc_type && state_code == 3'd0 && !core_reset) |=> state_code == 3'd1); // R2

  AST_GRANT_CYCLE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc_req && bus_cyc_type) |-> state_code == 3'd2); // R4

  AST_CLKOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd3 && $past(state_code) != 3'd3) |-> $past(state_code) == 3'd2); // R6

  AST_CLKOFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    state_code == 3'd3 |-> (!bus_cyc_req && !core_clk_en)); // R7

  AST_FLOAT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0 || state_code == 3'd3) |-> !bus_float); // R8

  AST_SNOOP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd4 && !core_reset) |=> (state_code == $past(state_code, 2) && !bus_cyc_req)); // R9

  AST_CLKEN_IN_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> state_code == 3'd4); // R9

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_reset   (core_reset),
  .bus_cyc_req  (bus_cyc_req),
  .bus_cyc_type (bus_cyc_type),
  .bus_float    (bus_float),
  .core_clk_en  (core_clk_en),
  .state_code   (state_code)
);

// File: tb/pwr_state_ctrl_test.sv
`timescale 1ns/1ps
module pwr_state_ctrl_test;

  localparam int LOCK = 5;

  logic clk = 1'b0;
  logic rst_n, core_reset, soft_reset, halt_exec, stop_req_n, clk_running;
  logic irq_maskable, irq_nonmask, irq_mgmt_n;
  logic bus_hold_req, addr_hold_req, backoff_req_n, snoop_req_n;
  logic bus_cyc_req, bus_cyc_type, bus_float, core_clk_en;
  logic [2:0] state_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_state_ctrl #(.LOCK_TICKS(LOCK)) uut (
    .clk(clk), .rst_n(rst_n), .core_reset(core_reset), .soft_reset(soft_reset),
    .halt_exec(halt_exec), .stop_req_n(stop_req_n), .clk_running(clk_running),
    .irq_maskable(irq_maskable), .irq_nonmask(irq_nonmask), .irq_mgmt_n(irq_mgmt_n),
    .bus_hold_req(bus_hold_req), .addr_hold_req(addr_hold_req),
    .backoff_req_n(backoff_req_n), .snoop_req_n(snoop_req_n),
    .bus_cyc_req(bus_cyc_req), .bus_cyc_type(bus_cyc_type), .bus_float(bus_float),
    .core_clk_en(core_clk_en), .state_code(state_code)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model: 0 run, 1 halted, 2 grant, 3 clock off, 4 snoop, 5 halt announce
  int m_st, m_ret, m_fh, m_cnt, m_req, m_typ, m_ns;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ret = 1; m_fh = 0; m_cnt = 0; m_req = 0; m_typ = 0;
    end else begin
      m_ns = m_st; m_req = 0; m_typ = 0;
      if (core_reset) begin
        m_ns = 0; m_fh = 0;
      end else begin
        case (m_st)
          0: if (!stop_req_n) begin m_ns = 2; m_req = 1; m_typ = 1; m_fh = 0; end
             else if (halt_exec) begin m_ns = 5; m_req = 1; end
          5: m_ns = 1;
          1: if (irq_maskable || irq_nonmask || !irq_mgmt_n || soft_reset) m_ns = 0;
             else if (!stop_req_n) begin m_ns = 2; m_req = 1; m_typ = 1; m_fh = 1; end
             else if (!snoop_req_n) begin m_ns = 4; m_ret = 1; end
          2: if (!clk_running) m_ns = 3;
             else if (stop_req_n) begin
               if (m_fh != 0) begin m_ns = 1; m_req = 1; end
               else m_ns = 0;
             end else if (!snoop_req_n) begin m_ns = 4; m_ret = 2; end
          3: if (clk_running) begin
               m_cnt++;
               if (m_cnt >= LOCK) m_ns = 2;
             end else m_cnt = 0;
          4: m_ns = m_ret;
          default: m_ns = 0;
        endcase
      end
      if (m_ns == 3 && m_st != 3) m_cnt = 0;
      m_st = m_ns;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 state code vs model", int'(state_code), (m_st == 5) ? 0 : m_st);
      chk("R11 bus request vs model", int'(bus_cyc_req), m_req);
      if (m_req != 0) chk("R11 cycle type vs model", int'(bus_cyc_type), m_typ);
      chk("R9 core clock enable vs model", int'(core_clk_en), (m_st == 4) ? 1 : 0);
      chk("R8 bus float vs model", int'(bus_float),
          ((m_st == 1 || m_st == 2 || m_st == 4) &&
           (bus_hold_req || addr_hold_req || !backoff_req_n)) ? 1 : 0);
    end
  end

  task automatic step();
    @(posedge clk);
    #3;
  endtask

  task automatic enter_halt();
    halt_exec = 1'b1;
    step();
    halt_exec = 1'b0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; core_reset = 1'b0; soft_reset = 1'b0; halt_exec = 1'b0;
    stop_req_n = 1'b1; clk_running = 1'b1; irq_maskable = 1'b0; irq_nonmask = 1'b0;
    irq_mgmt_n = 1'b1; bus_hold_req = 1'b0; addr_hold_req = 1'b0;
    backoff_req_n = 1'b1; snoop_req_n = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 reset state", int'(state_code), 0);
    chk("R1 reset request", int'(bus_cyc_req), 0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", int'(state_code), 0);
    chk("R1 clock enable", int'(core_clk_en), 0);

    // R2 halt cycle then halted
    halt_exec = 1'b1;
    step();
    halt_exec = 1'b0;
    chk("R2 code during announce", int'(state_code), 0);
    chk("R2 request", int'(bus_cyc_req), 1);
    chk("R2 type", int'(bus_cyc_type), 0);
    step();
    chk("R2 halted", int'(state_code), 1);
    chk("R2 single pulse", int'(bus_cyc_req), 0);

    // R8 each hold source in halted
    bus_hold_req = 1'b1; #1 chk("R8 hold", int'(bus_float), 1);
    bus_hold_req = 1'b0; addr_hold_req = 1'b1; #1 chk("R8 addr hold", int'(bus_float), 1);
    addr_hold_req = 1'b0; backoff_req_n = 1'b0; #1 chk("R8 backoff", int'(bus_float), 1);
    backoff_req_n = 1'b1; #1 chk("R8 released", int'(bus_float), 0);

    // R3 each wake source
    for (int k = 0; k < 4; k++) begin
      if (k > 0) enter_halt();
      case (k)
        0: irq_maskable = 1'b1;
        1: irq_nonmask = 1'b1;
        2: irq_mgmt_n = 1'b0;
        default: soft_reset = 1'b1;
      endcase
      step();
      chk("R3 wake to run", int'(state_code), 0);
      chk("R3 no request", int'(bus_cyc_req), 0);
      irq_maskable = 1'b0; irq_nonmask = 1'b0; irq_mgmt_n = 1'b1; soft_reset = 1'b0;
    end

    // R8 no float in run; R6 stopped clock ignored in run
    bus_hold_req = 1'b1; #1 chk("R8 run no float", int'(bus_float), 0);
    bus_hold_req = 1'b0;
    clk_running = 1'b0;
    step();
    chk("R6 run ignores clock stop", int'(state_code), 0);
    clk_running = 1'b1;

    // R4 and R5 from run
    stop_req_n = 1'b0;
    step();
    chk("R4 grant from run", int'(state_code), 2);
    chk("R4 request", int'(bus_cyc_req), 1);
    chk("R4 type", int'(bus_cyc_type), 1);
    step();
    chk("R11 pulse ends", int'(bus_cyc_req), 0);
    stop_req_n = 1'b1;
    step();
    chk("R5 back to run", int'(state_code), 0);
    chk("R5 no request", int'(bus_cyc_req), 0);

    // R4 from halted
    enter_halt();
    stop_req_n = 1'b0;
    step();
    chk("R4 grant from halted", int'(state_code), 2);
    chk("R4 grant type", int'(bus_cyc_type), 1);

    // R9 snoop in grant with bus floated
    snoop_req_n = 1'b0; bus_hold_req = 1'b1;
    step();
    snoop_req_n = 1'b1;
    chk("R9 snoop state", int'(state_code), 4);
    chk("R9 clock enable", int'(core_clk_en), 1);
    #1 chk("R8 float in snoop", int'(bus_float), 1);
    step();
    chk("R9 back to grant", int'(state_code), 2);
    chk("R9 enable one cycle", int'(core_clk_en), 0);
    chk("R9 silent return", int'(bus_cyc_req), 0);
    bus_hold_req = 1'b0;

    // R6 and R7 clock stop and relock
    clk_running = 1'b0;
    step();
    chk("R6 clock off", int'(state_code), 3);
    irq_maskable = 1'b1; snoop_req_n = 1'b0;
    step();
    step();
    chk("R7 ignores irq and snoop", int'(state_code), 3);
    chk("R7 no snoop clock", int'(core_clk_en), 0);
    snoop_req_n = 1'b1;
    clk_running = 1'b1;
    repeat (LOCK - 1) step();
    chk("R7 still waiting", int'(state_code), 3);
    clk_running = 1'b0;
    step();
    clk_running = 1'b1;
    repeat (LOCK - 1) step();
    chk("R7 gap restarted wait", int'(state_code), 3);
    step();
    chk("R7 relocked", int'(state_code), 2);
    chk("R7 no request", int'(bus_cyc_req), 0);

    // R5 and R10 release with interrupt held
    stop_req_n = 1'b1;
    step();
    chk("R5 back to halted", int'(state_code), 1);
    chk("R5 new halt cycle", int'(bus_cyc_req), 1);
    chk("R5 halt type", int'(bus_cyc_type), 0);
    step();
    chk("R10 held irq serviced", int'(state_code), 0);
    irq_maskable = 1'b0;

    // R9 snoop in halted
    enter_halt();
    snoop_req_n = 1'b0;
    step();
    snoop_req_n = 1'b1;
    chk("R9 snoop from halted", int'(state_code), 4);
    step();
    chk("R9 back to halted", int'(state_code), 1);

    // R1 core reset in grant and against a halt strobe
    stop_req_n = 1'b0;
    step();
    core_reset = 1'b1;
    step();
    chk("R1 core reset from grant", int'(state_code), 0);
    chk("R1 core reset request", int'(bus_cyc_req), 0);
    core_reset = 1'b0; stop_req_n = 1'b1;
    step();
    chk("R1 stays run", int'(state_code), 0);
    core_reset = 1'b1; halt_exec = 1'b1;
    step();
    chk("R1 beats halt", int'(bus_cyc_req), 0);
    core_reset = 1'b0; halt_exec = 1'b0;
    step();

    // R11 grant then immediate release from run
    stop_req_n = 1'b0;
    step();
    stop_req_n = 1'b1;
    step();
    chk("R11 no release request", int'(bus_cyc_req), 0);
    step();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule